// File: doc/BRIEF.md
# Full-Speed OUT Endpoint Handshake Controller

This block makes the per-packet decisions for one receive (host-to-device) endpoint of a full-speed USB device. A packet decoder hands it one finished data packet at a time: whether the token was SETUP, the data PID, the frame parity, the CRC verdict and the byte count. Within one cycle the block chooses a handshake (ACK, NAK or none) and tells the receive FIFO whether to keep the payload. It also tracks the bytes still expected in the current transfer and raises one interrupt pulse when a transfer ends, when a SETUP stage ends, or when a disable request takes effect.

Software drives the control bits as one-cycle pulses: arm the endpoint, request a disable, set or clear the NAK state, and force the expected-PID / frame-parity bit to one. It also sets the endpoint kind, the snoop option and a 2-bit max-packet code as levels. A five-state machine runs each packet. IDLE waits for a packet or a pending disable. It moves to DECIDE on a packet, or to CLOSE on a pending disable. DECIDE registers the verdict and always moves to REPLY. REPLY presents the handshake and the FIFO strobe for one cycle, then moves to CLOSE if the packet ends a stage, otherwise back to IDLE. CLOSE clears the arm and disable bits and always moves to NOTIFY. NOTIFY pulses the interrupt for the stored cause and returns to IDLE.

Top module: `usb_out_ep`

## Requirements
- R1: After reset, ep_en, ep_dis_pend, nak_sts and exp_bit are 0, and no handshake, FIFO strobe or interrupt is active.
- R2: A pulse on sw_enable_set sets ep_en and loads the transfer byte count. Hardware clears ep_en in the cycle before any interrupt pulse, and at most one interrupt pulses at a time.
- R3: sw_disable_req sets ep_dis_pend only while ep_en is 1, and otherwise has no effect. Once the request is pending, ep_en and ep_dis_pend are both 0 when irq_ep_disabled pulses, two cycles after the pending bit appears.
- R4: sw_set_nak sets nak_sts and sw_clr_nak clears it; set wins if both pulse together. While nak_sts is 1, every valid non-SETUP data packet gets a NAK and is not written to the FIFO.
- R5: A SETUP packet with a good CRC always gets ACK and is written to the FIFO, whatever nak_sts and ep_en are. It sets exp_bit to 1, ends the stage, and pulses irq_setup_done.
- R6: When fifo_free is less than the maximum packet size, a non-SETUP packet gets a NAK and is not written.
- R7: On control, bulk and interrupt kinds (ep_kind 00, 10, 11), a packet whose PID matches exp_bit (pkt_data1=1 means DATA1) gets ACK, is written, and toggles exp_bit. A mismatched PID gets ACK, is not written, and leaves exp_bit unchanged.
- R8: A transfer ends when a written packet is shorter than the maximum packet size or brings the received byte count up to the programmed count. irq_xfer_done then pulses after ep_en has cleared.
- R9: A packet with pkt_crc_ok=0 gets no handshake and is not written, unless snoop_en=1, in which case it is handled as if its CRC were good.
- R10: A pulse on sw_set_data1 sets exp_bit to 1. On bulk and interrupt kinds this bit is the expected DATA1 PID; on the isochronous kind (ep_kind 01) it means odd frame parity is expected.
- R11: Isochronous packets never get a handshake. A packet whose pkt_frame_odd differs from exp_bit is dropped. A matching one is written (if enabled, not NAKed and with room) and toggles exp_bit.
- R12: The maximum packet size follows mps_code: 00 gives 64, 01 gives 32, 10 gives 16 and 11 gives 8 bytes.
- R13: A non-SETUP data packet that arrives while ep_en is 0 gets a NAK and is not written.
- R14: The handshake and the FIFO strobe are valid for exactly the one cycle that begins one clock edge after the edge at which pkt_valid is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_kind | input | 2 | Endpoint kind: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| snoop_en | input | 1 | Accept packets without a CRC check |
| mps_code | input | 2 | Maximum packet size code |
| sw_xfer_bytes | input | XFER_W | Transfer byte count, loaded on arm |
| sw_enable_set | input | 1 | Arm pulse (write-1-to-set) |
| sw_disable_req | input | 1 | Disable request pulse |
| sw_set_nak | input | 1 | Set NAK state pulse |
| sw_clr_nak | input | 1 | Clear NAK state pulse |
| sw_set_data1 | input | 1 | Force expected DATA1 / odd-frame pulse |
| pkt_valid | input | 1 | One-cycle strobe: a packet has finished |
| pkt_setup | input | 1 | Packet followed a SETUP token |
| pkt_data1 | input | 1 | Packet PID is DATA1 |
| pkt_frame_odd | input | 1 | Packet arrived in an odd frame |
| pkt_crc_ok | input | 1 | CRC check passed |
| pkt_len | input | log2(MAX_MPS)+1 | Payload byte count |
| fifo_free | input | FREE_W | Free bytes in the receive FIFO |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_ack | output | 1 | Handshake is ACK (1) or NAK (0) |
| rx_commit | output | 1 | Keep the payload in the FIFO |
| ep_en | output | 1 | Endpoint armed |
| ep_dis_pend | output | 1 | Disable request pending |
| nak_sts | output | 1 | NAK state |
| exp_bit | output | 1 | Expected DATA1 PID / odd frame |
| irq_xfer_done | output | 1 | Transfer-complete pulse |
| irq_setup_done | output | 1 | SETUP-stage-done pulse |
| irq_ep_disabled | output | 1 | Endpoint-disabled pulse |

## Verification
The assertions assume that the decoder presents a packet only while the machine is in IDLE. They also assume that ep_kind and nak_sts do not change between the strobe and the handshake, so the PID, SETUP and kind seen two edges before a handshake are the ones it answers. The stimulus respects these limits. It spaces packets at least seven cycles apart, changes levels such as ep_kind, fifo_free and mps_code only while no packet is in flight, and issues control pulses only between packets.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'b00,
        EP_ISO  = 2'b01,
        EP_BULK = 2'b10,
        EP_INTR = 2'b11
    } ep_kind_e;

    typedef enum logic [1:0] {
        CL_NONE,
        CL_XFER,
        CL_SETUP,
        CL_DIS
    } close_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_REPLY,
        ST_CLOSE,
        ST_NOTIFY
    } ep_state_e;

    // Outcome of one packet
    typedef struct packed {
        logic hs;     // send a handshake
        logic ack;    // ACK when 1, NAK when 0
        logic keep;   // payload goes to the FIFO
        logic adv;    // toggle expected PID / parity
        logic fin;    // stage ends after this packet
        logic setup;  // packet was a SETUP
    } verdict_t;

endpackage

// File: rtl/usb_out_ep_judge.sv
module usb_out_ep_judge
    import usb_out_ep_pkg::*;
#(
    parameter int MAX_MPS = 64,
    parameter int XFER_W  = 16,
    parameter int FREE_W  = 10,
    parameter int LEN_W   = $clog2(MAX_MPS) + 1
) (
    input  ep_kind_e          kind,
    input  logic              snoop_en,
    input  logic [1:0]        mps_code,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              en_q,
    input  logic              nak_q,
    input  logic              exp_q,
    input  logic [XFER_W-1:0] rem_q,
    input  logic              lat_setup,
    input  logic              lat_data1,
    input  logic              lat_odd,
    input  logic              lat_ok,
    input  logic [LEN_W-1:0]  lat_len,
    output verdict_t          verdict
);

    localparam logic [LEN_W-1:0] MPS_TOP = LEN_W'(MAX_MPS);

    logic [LEN_W-1:0] mps;
    logic room, good, last;

    always_comb begin
        mps  = MPS_TOP >> mps_code;
        room = 32'(fifo_free) >= 32'(mps);
        good = lat_ok || snoop_en;
        last = (lat_len < mps) || (32'(lat_len) >= 32'(rem_q));
    end

    always_comb begin
        verdict = '0;
        if (!good) begin
            verdict = '0;
        end else if (lat_setup) begin
            verdict.hs    = 1'b1;
            verdict.ack   = 1'b1;
            verdict.keep  = 1'b1;
            verdict.fin   = 1'b1;
            verdict.setup = 1'b1;
        end else if (kind == EP_ISO) begin
            verdict.keep = en_q && !nak_q && room && (lat_odd == exp_q);
            verdict.adv  = verdict.keep;
            verdict.fin  = verdict.keep && last;
        end else if (!en_q || nak_q || !room) begin
            verdict.hs = 1'b1;
        end else if (lat_data1 != exp_q) begin
            verdict.hs  = 1'b1;
            verdict.ack = 1'b1;
        end else begin
            verdict.hs   = 1'b1;
            verdict.ack  = 1'b1;
            verdict.keep = 1'b1;
            verdict.adv  = 1'b1;
            verdict.fin  = last;
        end
    end

endmodule

// File: rtl/usb_out_ep_regs.sv
module usb_out_ep_regs
    import usb_out_ep_pkg::*;
#(
    parameter int XFER_W = 16,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_enable_set,
    input  logic              sw_disable_req,
    input  logic              sw_set_nak,
    input  logic              sw_clr_nak,
    input  logic              sw_set_data1,
    input  logic [XFER_W-1:0] sw_xfer_bytes,
    input  logic              hw_close,
    input  logic              hw_apply,
    input  verdict_t          verdict,
    input  logic [LEN_W-1:0]  lat_len,
    output logic              en_q,
    output logic              dis_q,
    output logic              nak_q,
    output logic              exp_q,
    output logic [XFER_W-1:0] rem_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dis_q <= 1'b0;
        end else if (hw_close) begin
            en_q  <= 1'b0;
            dis_q <= 1'b0;
        end else begin
            if (sw_enable_set) en_q <= 1'b1;
            if (sw_disable_req && en_q) dis_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) nak_q <= 1'b0;
        else if (sw_set_nak) nak_q <= 1'b1;
        else if (sw_clr_nak) nak_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) exp_q <= 1'b0;
        else if (sw_set_data1) exp_q <= 1'b1;
        else if (hw_apply && verdict.setup) exp_q <= 1'b1;
        else if (hw_apply && verdict.adv) exp_q <= !exp_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else if (sw_enable_set && !hw_close) rem_q <= sw_xfer_bytes;
        else if (hw_apply && verdict.keep && !verdict.setup)
            rem_q <= rem_q - XFER_W'(lat_len);
    end

endmodule

// File: rtl/usb_out_ep_fsm.sv
module usb_out_ep_fsm
    import usb_out_ep_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic             pkt_setup,
    input  logic             pkt_data1,
    input  logic             pkt_frame_odd,
    input  logic             pkt_crc_ok,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             dis_q,
    input  verdict_t         verdict,
    output ep_state_e        state_q,
    output logic             lat_setup,
    output logic             lat_data1,
    output logic             lat_odd,
    output logic             lat_ok,
    output logic [LEN_W-1:0] lat_len,
    output logic             hs_valid,
    output logic             hs_ack,
    output logic             rx_commit,
    output logic             irq_xfer_done,
    output logic             irq_setup_done,
    output logic             irq_ep_disabled
);

    ep_state_e state_d;
    verdict_t  verdict_q;
    close_e    cause_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pkt_valid)  state_d = ST_DECIDE;
                else if (dis_q) state_d = ST_CLOSE;
            end
            ST_DECIDE: state_d = ST_REPLY;
            ST_REPLY:  state_d = verdict_q.fin ? ST_CLOSE : ST_IDLE;
            ST_CLOSE:  state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_setup <= 1'b0;
            lat_data1 <= 1'b0;
            lat_odd   <= 1'b0;
            lat_ok    <= 1'b0;
            lat_len   <= '0;
            verdict_q <= '0;
            cause_q   <= CL_NONE;
        end else begin
            if (state_q == ST_IDLE && pkt_valid) begin
                lat_setup <= pkt_setup;
                lat_data1 <= pkt_data1;
                lat_odd   <= pkt_frame_odd;
                lat_ok    <= pkt_crc_ok;
                lat_len   <= pkt_len;
            end
            if (state_q == ST_IDLE && !pkt_valid && dis_q) cause_q <= CL_DIS;
            if (state_q == ST_DECIDE) begin
                verdict_q <= verdict;
                cause_q   <= verdict.setup ? CL_SETUP : (verdict.fin ? CL_XFER : CL_NONE);
            end
        end
    end

    always_comb begin
        hs_valid        = 1'b0;
        hs_ack          = 1'b0;
        rx_commit       = 1'b0;
        irq_xfer_done   = 1'b0;
        irq_setup_done  = 1'b0;
        irq_ep_disabled = 1'b0;
        unique case (state_q)
            ST_REPLY: begin
                hs_valid  = verdict_q.hs;
                hs_ack    = verdict_q.hs && verdict_q.ack;
                rx_commit = verdict_q.keep;
            end
            ST_NOTIFY: begin
                irq_xfer_done   = (cause_q == CL_XFER);
                irq_setup_done  = (cause_q == CL_SETUP);
                irq_ep_disabled = (cause_q == CL_DIS);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/usb_out_ep.sv
module usb_out_ep
    import usb_out_ep_pkg::*;
#(
    parameter int MAX_MPS = 64,
    parameter int XFER_W  = 16,
    parameter int FREE_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                ep_kind,
    input  logic                      snoop_en,
    input  logic [1:0]                mps_code,
    input  logic [XFER_W-1:0]         sw_xfer_bytes,
    input  logic                      sw_enable_set,
    input  logic                      sw_disable_req,
    input  logic                      sw_set_nak,
    input  logic                      sw_clr_nak,
    input  logic                      sw_set_data1,
    input  logic                      pkt_valid,
    input  logic                      pkt_setup,
    input  logic                      pkt_data1,
    input  logic                      pkt_frame_odd,
    input  logic                      pkt_crc_ok,
    input  logic [$clog2(MAX_MPS):0]  pkt_len,
    input  logic [FREE_W-1:0]         fifo_free,
    output logic                      hs_valid,
    output logic                      hs_ack,
    output logic                      rx_commit,
    output logic                      ep_en,
    output logic                      ep_dis_pend,
    output logic                      nak_sts,
    output logic                      exp_bit,
    output logic                      irq_xfer_done,
    output logic                      irq_setup_done,
    output logic                      irq_ep_disabled
);

    localparam int LEN_W = $clog2(MAX_MPS) + 1;

    ep_state_e         state_q;
    verdict_t          verdict;
    logic              lat_setup, lat_data1, lat_odd, lat_ok;
    logic [LEN_W-1:0]  lat_len;
    logic [XFER_W-1:0] rem_q;
    logic              en_q, dis_q, nak_q, exp_q;

    usb_out_ep_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .pkt_valid       (pkt_valid),
        .pkt_setup       (pkt_setup),
        .pkt_data1       (pkt_data1),
        .pkt_frame_odd   (pkt_frame_odd),
        .pkt_crc_ok      (pkt_crc_ok),
        .pkt_len         (pkt_len),
        .dis_q           (dis_q),
        .verdict         (verdict),
        .state_q         (state_q),
        .lat_setup       (lat_setup),
        .lat_data1       (lat_data1),
        .lat_odd         (lat_odd),
        .lat_ok          (lat_ok),
        .lat_len         (lat_len),
        .hs_valid        (hs_valid),
        .hs_ack          (hs_ack),
        .rx_commit       (rx_commit),
        .irq_xfer_done   (irq_xfer_done),
        .irq_setup_done  (irq_setup_done),
        .irq_ep_disabled (irq_ep_disabled)
    );

    usb_out_ep_judge #(
        .MAX_MPS (MAX_MPS),
        .XFER_W  (XFER_W),
        .FREE_W  (FREE_W),
        .LEN_W   (LEN_W)
    ) u_judge (
        .kind      (ep_kind_e'(ep_kind)),
        .snoop_en  (snoop_en),
        .mps_code  (mps_code),
        .fifo_free (fifo_free),
        .en_q      (en_q),
        .nak_q     (nak_q),
        .exp_q     (exp_q),
        .rem_q     (rem_q),
        .lat_setup (lat_setup),
        .lat_data1 (lat_data1),
        .lat_odd   (lat_odd),
        .lat_ok    (lat_ok),
        .lat_len   (lat_len),
        .verdict   (verdict)
    );

    usb_out_ep_regs #(.XFER_W(XFER_W), .LEN_W(LEN_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_enable_set  (sw_enable_set),
        .sw_disable_req (sw_disable_req),
        .sw_set_nak     (sw_set_nak),
        .sw_clr_nak     (sw_clr_nak),
        .sw_set_data1   (sw_set_data1),
        .sw_xfer_bytes  (sw_xfer_bytes),
        .hw_close       (state_q == ST_CLOSE),
        .hw_apply       (state_q == ST_DECIDE),
        .verdict        (verdict),
        .lat_len        (lat_len),
        .en_q           (en_q),
        .dis_q          (dis_q),
        .nak_q          (nak_q),
        .exp_q          (exp_q),
        .rem_q          (rem_q)
    );

    assign ep_en       = en_q;
    assign ep_dis_pend = dis_q;
    assign nak_sts     = nak_q;
    assign exp_bit     = exp_q;

endmodule

// File: rtl/usb_out_ep_chk.sv
module usb_out_ep_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ep_kind,
    input logic       pkt_valid,
    input logic       pkt_setup,
    input logic       pkt_crc_ok,
    input logic       hs_valid,
    input logic       hs_ack,
    input logic       rx_commit,
    input logic       ep_en,
    input logic       ep_dis_pend,
    input logic       nak_sts,
    input logic       irq_xfer_done,
    input logic       irq_setup_done,
    input logic       irq_ep_disabled
);

    assert_irq_after_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_xfer_done || irq_setup_done || irq_ep_disabled) |-> (!ep_en && !ep_dis_pend));

    assert_irq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_xfer_done, irq_setup_done, irq_ep_disabled}));

    assert_dis_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ep_dis_pend) |-> $past(ep_en));

    assert_nak_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && !hs_ack) |-> !rx_commit);

    assert_nak_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && $past(nak_sts) && !$past(pkt_setup, 2)) |-> !hs_ack);

    assert_setup_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pkt_valid, 2) && $past(pkt_setup, 2) && $past(pkt_crc_ok, 2))
        |-> (hs_valid && hs_ack && rx_commit));

    assert_iso_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> ($past(ep_kind) != 2'b01 || $past(pkt_setup, 2)));

    assert_reply_latency_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid || rx_commit) |-> $past(pkt_valid, 2));

endmodule

bind usb_out_ep usb_out_ep_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ep_kind         (ep_kind),
    .pkt_valid       (pkt_valid),
    .pkt_setup       (pkt_setup),
    .pkt_crc_ok      (pkt_crc_ok),
    .hs_valid        (hs_valid),
    .hs_ack          (hs_ack),
    .rx_commit       (rx_commit),
    .ep_en           (ep_en),
    .ep_dis_pend     (ep_dis_pend),
    .nak_sts         (nak_sts),
    .irq_xfer_done   (irq_xfer_done),
    .irq_setup_done  (irq_setup_done),
    .irq_ep_disabled (irq_ep_disabled)
);

// File: tb/usb_out_ep_bench.sv
`timescale 1ns/1ps
module usb_out_ep_bench;

    localparam int MAX_MPS = 64;
    localparam int XFER_W  = 16;
    localparam int FREE_W  = 10;
    localparam int LEN_W   = $clog2(MAX_MPS) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        ep_kind = 2'b10;
    logic              snoop_en = 1'b0;
    logic [1:0]        mps_code = 2'b00;
    logic [XFER_W-1:0] sw_xfer_bytes = '0;
    logic              sw_enable_set = 1'b0, sw_disable_req = 1'b0;
    logic              sw_set_nak = 1'b0, sw_clr_nak = 1'b0, sw_set_data1 = 1'b0;
    logic              pkt_valid = 1'b0, pkt_setup = 1'b0, pkt_data1 = 1'b0;
    logic              pkt_frame_odd = 1'b0, pkt_crc_ok = 1'b1;
    logic [LEN_W-1:0]  pkt_len = '0;
    logic [FREE_W-1:0] fifo_free = 10'd512;
    logic hs_valid, hs_ack, rx_commit, ep_en, ep_dis_pend, nak_sts, exp_bit;
    logic irq_xfer_done, irq_setup_done, irq_ep_disabled;

    always #2 clk = ~clk;

    usb_out_ep #(.MAX_MPS(MAX_MPS), .XFER_W(XFER_W), .FREE_W(FREE_W)) u_usb_out_ep (.*);

    typedef struct {
        logic [2:0] resp;   // {hs_valid, ack, commit}
        logic [2:0] irq;    // {xfer_done, setup_done, disabled}
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic send(input bit setup, input bit d1, input bit odd, input bit ok,
                        input int len, input logic [2:0] resp, input logic [2:0] irq,
                        input string req);
        exp_t e;
        e.resp = resp; e.irq = irq; e.req = req;
        @(negedge clk);
        pkt_setup = setup; pkt_data1 = d1; pkt_frame_odd = odd;
        pkt_crc_ok = ok; pkt_len = LEN_W'(len);
        q.push_back(e);
        pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Monitor: R14 one-cycle reply window, then the stage interrupt
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (pkt_valid === 1'b1 && rst_n === 1'b1) begin
                @(posedge clk); #1;
                if (q.size() == 0) begin
                    check(1'b0, "R14 unexpected packet", 0, 1);
                end else begin
                    e = q.pop_front();
                    check({hs_valid, hs_ack, rx_commit} == e.resp, {e.req, " R14 reply"},
                          int'({hs_valid, hs_ack, rx_commit}), int'(e.resp));
                    @(posedge clk); @(posedge clk); #1;
                    check({irq_xfer_done, irq_setup_done, irq_ep_disabled} == e.irq,
                          {e.req, " irq"},
                          int'({irq_xfer_done, irq_setup_done, irq_ep_disabled}), int'(e.irq));
                    if (e.irq != 3'b000)
                        check(ep_en == 1'b0, {e.req, " R2 en cleared"}, int'(ep_en), 0);
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check({ep_en, ep_dis_pend, nak_sts, exp_bit} == 4'b0, "R1 status", int'({ep_en, ep_dis_pend, nak_sts, exp_bit}), 0);
        check({hs_valid, rx_commit, irq_xfer_done, irq_setup_done, irq_ep_disabled} == 5'b0,
              "R1 strobes", int'({hs_valid, rx_commit, irq_xfer_done, irq_setup_done, irq_ep_disabled}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R13 not armed
        send(0, 0, 0, 1, 64, 3'b100, 3'b000, "R13");
        // R3 disable ignored when not armed
        pulse(sw_disable_req);
        @(negedge clk);
        check(ep_dis_pend == 1'b0, "R3 ignored", int'(ep_dis_pend), 0);
        check(ep_en == 1'b0, "R3 no arm", int'(ep_en), 0);

        // R2 arm
        sw_xfer_bytes = 16'd128;
        pulse(sw_enable_set);
        check(ep_en == 1'b1, "R2 arm", int'(ep_en), 1);

        // R7 toggle and mismatch
        send(0, 0, 0, 1, 64, 3'b111, 3'b000, "R7 match");
        check(exp_bit == 1'b1, "R7 toggled", int'(exp_bit), 1);
        send(0, 0, 0, 1, 64, 3'b110, 3'b000, "R7 mismatch");
        check(exp_bit == 1'b1, "R7 held", int'(exp_bit), 1);

        // R4 NAK state
        pulse(sw_set_nak);
        check(nak_sts == 1'b1, "R4 set", int'(nak_sts), 1);
        send(0, 1, 0, 1, 64, 3'b100, 3'b000, "R4 refuse");
        pulse(sw_clr_nak);
        check(nak_sts == 1'b0, "R4 clear", int'(nak_sts), 0);

        // R6 no room for 64
        fifo_free = 10'd40;
        send(0, 1, 0, 1, 64, 3'b100, 3'b000, "R6 room");
        fifo_free = 10'd512;

        // R9 bad CRC ignored, then snoop accepts; ends count (R8)
        send(0, 1, 0, 0, 64, 3'b000, 3'b000, "R9 bad crc");
        snoop_en = 1'b1;
        send(0, 1, 0, 0, 64, 3'b111, 3'b100, "R9 snoop R8 count");
        snoop_en = 1'b0;
        check(exp_bit == 1'b0, "R7 after snoop", int'(exp_bit), 0);

        // R12 code 01 = 32: 20 bytes is short, R8
        mps_code = 2'b01; sw_xfer_bytes = 16'd200;
        pulse(sw_enable_set);
        send(0, 0, 0, 1, 20, 3'b111, 3'b100, "R12 R8 short");

        // R10 bulk force DATA1
        mps_code = 2'b00; sw_xfer_bytes = 16'd64;
        pulse(sw_enable_set);
        send(0, 1, 0, 1, 32, 3'b111, 3'b100, "R8 short 32");
        check(exp_bit == 1'b0, "R10 pre", int'(exp_bit), 0);
        pulse(sw_set_data1);
        check(exp_bit == 1'b1, "R10 bulk", int'(exp_bit), 1);

        // R12 code 11 = 8: room with 40 free, full 8-byte packet not short
        mps_code = 2'b11; sw_xfer_bytes = 16'd100; fifo_free = 10'd40;
        pulse(sw_enable_set);
        send(0, 1, 0, 1, 8, 3'b111, 3'b000, "R12 code3");
        fifo_free = 10'd512; mps_code = 2'b00;

        // R5 SETUP bypasses NAK
        pulse(sw_set_nak);
        send(1, 0, 0, 1, 8, 3'b111, 3'b010, "R5 setup");
        check(exp_bit == 1'b1, "R5 exp", int'(exp_bit), 1);
        pulse(sw_clr_nak);

        // R11 isochronous parity
        ep_kind = 2'b01; sw_xfer_bytes = 16'd1000;
        pulse(sw_enable_set);
        send(0, 0, 0, 1, 64, 3'b000, 3'b000, "R11 wrong parity");
        send(0, 0, 1, 1, 64, 3'b001, 3'b000, "R11 match");
        check(exp_bit == 1'b0, "R11 toggled", int'(exp_bit), 0);
        pulse(sw_set_data1);
        check(exp_bit == 1'b1, "R10 iso odd", int'(exp_bit), 1);

        // R3 disable while armed
        ep_kind = 2'b10;
        pulse(sw_disable_req);
        check(ep_dis_pend == 1'b1, "R3 pending", int'(ep_dis_pend), 1);
        @(negedge clk);
        check(irq_ep_disabled == 1'b0, "R3 not yet", int'(irq_ep_disabled), 0);
        @(negedge clk);
        check(irq_ep_disabled == 1'b1, "R3 irq", int'(irq_ep_disabled), 1);
        check({ep_en, ep_dis_pend} == 2'b00, "R3 R2 cleared", int'({ep_en, ep_dis_pend}), 0);

        repeat (4) @(negedge clk);
        check(q.size() == 0, "scoreboard drained", q.size(), 0);
        finished = 1;
        report();
    end

endmodule